// File: doc/BRIEF.md
# Memory-Backed Inbound Message Post Queue

This block runs a circular queue of 32-bit messages held in local memory. An external bus agent posts each message by writing to one queue port. The block stores the word in memory at the head pointer's byte address through a valid/ready write port, and then advances the head. A local processor reads the word at the tail address straight from memory, and then advances the tail with a register write. Both pointers cover a window of `DEPTH` four-byte slots that starts at `BASE`. `DEPTH` must be a power of two.

A flag that records which pointer moved last tells full from empty, so all `DEPTH` slots can hold a message. A queue-port request receives either an ack or a retry in the same cycle. It is retried while an earlier post is still being stored, and while the queue is full. Every completed post sets a pending bit, which software clears by writing 1 to it. The interrupt output is that bit gated by a mask. It is raised again only by a new post, never by a queue that merely holds messages.

The controller has two states, named here with their transitions. IDLE goes to STORE when a request is accepted (ACCEPT). STORE goes back to IDLE when memory takes the write (COMMIT). In the cycle after COMMIT, the head has advanced and new requests can be accepted.

Top module: `msgq_post_ctrl`

## Requirements
- R1: An accepted queue-port write drives `mem_valid` with `mem_addr` equal to the head byte address and `mem_data` equal to the posted word. Both stay stable until `mem_ready` is seen.
- R2: The head advances by 4 bytes in the cycle after the memory handshake. It wraps from `BASE+4*(DEPTH-1)` back to `BASE`.
- R3: A request gets `qp_ack` when the controller is in IDLE and the queue is not full. Otherwise it gets `qp_retry`. A request made while a post is in flight is retried, and its data is never stored.
- R4: While the queue is full (head equals tail and the head moved last), every request is retried until software advances the tail.
- R5: Only a register write moves the tail. Posts leave it unchanged. Register select 1 reads and writes the tail byte address, and select 0 does the same for the head.
- R6: Each completed post sets the pending bit (select 2, bit 0). `irq` equals pending AND NOT mask, where the mask is select 3, bit 0.
- R7: Writing 1 to pending clears it. It stays clear while messages remain, and it stays set if a post completes in the same cycle as the clear.
- R8: A software head write counts as a head update. Writing the head equal to the tail on an empty queue makes it full. Writing the tail equal to the head then empties it.
- R9: After reset both pointers read `BASE`, the queue is empty, pending and mask are 0, and `irq` is 0. Status select 2 reads bit 1 as full and bit 2 as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qp_req | input | 1 | Queue-port write request |
| qp_wdata | input | DW | Posted message |
| qp_ack | output | 1 | Request accepted this cycle |
| qp_retry | output | 1 | Request refused, retry later |
| mem_valid | output | 1 | Memory write pending |
| mem_addr | output | AW | Memory byte address |
| mem_data | output | DW | Memory write data |
| mem_ready | input | 1 | Memory takes the write |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 head, 1 tail, 2 status, 3 mask |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for the selected register |
| irq | output | 1 | Interrupt to the local processor |

## Verification
The hardest case to reach from the ports is a post that commits in the same cycle as the software clear of pending. The bench reaches it by holding `mem_ready` low after an accept, then raising it in the same cycle as the status write. The second-hardest case is a full queue. The bench fills the queue with posts that wrap past the last slot. It also forces full with a software head write on an empty queue, then keeps making requests. The remaining traffic mixes random posts and consumes under random memory stalls.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_STORE = 1'b1
    } post_state_t;

    typedef enum logic [1:0] {
        SEL_HEAD = 2'd0,
        SEL_TAIL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/msgq_ptr.sv
module msgq_ptr #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          load,
    input  logic [IW-1:0] load_idx,
    output logic [IW-1:0] idx
);
    // Increment has priority over a load in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (inc)
            idx <= idx + 1'b1;
        else if (load)
            idx <= load_idx;
    end
endmodule

// File: rtl/msgq_irq.sv
module msgq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic post_done,
    input  logic clr_we,
    input  logic clr_bit,
    input  logic mask_we,
    input  logic mask_bit,
    output logic pending,
    output logic mask,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (post_done)
            pending <= 1'b1;
        else if (clr_we && clr_bit)
            pending <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= 1'b0;
        else if (mask_we)
            mask <= mask_bit;
    end

    assign irq = pending & ~mask;
endmodule

// File: rtl/msgq_post_ctrl.sv
module msgq_post_ctrl
    import msgq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int DEPTH = 16,
    parameter logic [31:0] BASE = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          qp_req,
    input  logic [DW-1:0] qp_wdata,
    output logic          qp_ack,
    output logic          qp_retry,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ready,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [AW-1:0] BASE_A = AW'(BASE);

    post_state_t   state_q, state_d;
    logic [DW-1:0] msg_q;
    logic [IW-1:0] head_idx, tail_idx, wr_idx;
    logic [AW-1:0] head_addr, tail_addr, wr_off;
    logic          head_last;
    logic          full, empty, accept, commit;
    logic          head_we, tail_we, stat_we, mask_we;
    logic          pending, mask;
    reg_sel_t      sel;

    assign sel     = reg_sel_t'(reg_sel);
    assign head_we = reg_we && (sel == SEL_HEAD);
    assign tail_we = reg_we && (sel == SEL_TAIL);
    assign stat_we = reg_we && (sel == SEL_STAT);
    assign mask_we = reg_we && (sel == SEL_MASK);

    assign wr_off    = reg_wdata[AW-1:0] - BASE_A;
    assign wr_idx    = wr_off[IW+1:2];
    assign head_addr = BASE_A + AW'({head_idx, 2'b00});
    assign tail_addr = BASE_A + AW'({tail_idx, 2'b00});

    assign full  = (head_idx == tail_idx) && head_last;
    assign empty = (head_idx == tail_idx) && !head_last;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and transition strobes
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = qp_req && !full;
                if (accept)
                    state_d = ST_STORE;
            end
            ST_STORE: begin
                commit = mem_ready;
                if (commit)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        qp_ack    = 1'b0;
        qp_retry  = 1'b0;
        mem_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                qp_ack   = qp_req && !full;
                qp_retry = qp_req && full;
            end
            ST_STORE: begin
                mem_valid = 1'b1;
                qp_retry  = qp_req;
            end
            default: ;
        endcase
    end

    assign mem_addr = head_addr;
    assign mem_data = msg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            msg_q <= '0;
        else if (accept)
            msg_q <= qp_wdata;
    end

    // Records which pointer moved last; a head update wins a tie.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            head_last <= 1'b0;
        else if (commit || head_we)
            head_last <= 1'b1;
        else if (tail_we)
            head_last <= 1'b0;
    end

    msgq_ptr #(.IW(IW)) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (commit),
        .load     (head_we),
        .load_idx (wr_idx),
        .idx      (head_idx)
    );

    msgq_ptr #(.IW(IW)) u_tail (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (1'b0),
        .load     (tail_we),
        .load_idx (wr_idx),
        .idx      (tail_idx)
    );

    msgq_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_done (commit),
        .clr_we    (stat_we),
        .clr_bit   (reg_wdata[0]),
        .mask_we   (mask_we),
        .mask_bit  (reg_wdata[0]),
        .pending   (pending),
        .mask      (mask),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_HEAD: reg_rdata = DW'(head_addr);
            SEL_TAIL: reg_rdata = DW'(tail_addr);
            SEL_STAT: reg_rdata = DW'({empty, full, pending});
            SEL_MASK: reg_rdata = DW'(mask);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msgq_post_chk.sv
module msgq_post_chk #(
    parameter int IW = 4,
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          qp_req,
    input logic          qp_ack,
    input logic          qp_retry,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic [IW-1:0] head_idx,
    input logic          full,
    input logic          pending,
    input logic          mask,
    input logic          irq
);
    assert_resp_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(qp_ack && qp_retry));

    assert_resp_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (qp_ack || qp_retry) |-> qp_req);

    assert_busy_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && qp_req) |-> qp_retry);

    assert_full_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && qp_req) |-> qp_retry);

    assert_mem_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    assert_head_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> (head_idx == IW'($past(head_idx) + 1'b1)));

    assert_post_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> pending);

    assert_mask_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq);
endmodule

bind msgq_post_ctrl msgq_post_chk #(.IW(IW), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .qp_req    (qp_req),
    .qp_ack    (qp_ack),
    .qp_retry  (qp_retry),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .head_idx  (head_idx),
    .full      (full),
    .pending   (pending),
    .mask      (mask),
    .irq       (irq)
);

// File: tb/msgq_post_ctrl_tb.sv
module msgq_post_ctrl_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic qp_req = 1'b0;
    logic [DW-1:0] qp_wdata = '0;
    logic qp_ack, qp_retry, mem_valid, irq;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic mem_ready = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;

    always #5 clk = ~clk;

    msgq_post_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .qp_req(qp_req), .qp_wdata(qp_wdata),
        .qp_ack(qp_ack), .qp_retry(qp_retry), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Local memory model
    logic [DW-1:0] mem_model [DEPTH];
    always @(posedge clk)
        if (mem_valid && mem_ready)
            mem_model[(mem_addr - BASE) >> 2] <= mem_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int hi = 0, ti = 0;
    bit m_full = 0, m_pend = 0, m_mask = 0;
    logic [DW-1:0] exp_msg [DEPTH];
    logic [DW-1:0] rv;

    function automatic logic [31:0] addr_of(int idx);
        return BASE + 32'((idx % DEPTH) * 4);
    endfunction

    function automatic int count();
        if (m_full) return DEPTH;
        return (hi - ti + DEPTH) % DEPTH;
    endfunction

    function automatic logic [31:0] exp_stat();
        return {29'd0, (hi == ti) && !m_full, m_full, m_pend};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [DW-1:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic post(input logic [DW-1:0] d, input bit probe);
        int slot;
        @(negedge clk);
        qp_req = 1'b1; qp_wdata = d; mem_ready = 1'b0;
        #1;
        if (m_full) begin
            chk("R4 retry while full", {30'd0, qp_ack, qp_retry}, 32'd1);
            @(posedge clk);
            #1 qp_req = 1'b0;
            return;
        end
        chk("R3 ack when idle", {30'd0, qp_ack, qp_retry}, 32'd2);
        @(posedge clk);
        #1 qp_req = 1'b0;
        slot = hi;
        if (probe) begin
            @(negedge clk);
            qp_req = 1'b1; qp_wdata = ~d;
            #1;
            chk("R3 retry in flight", {30'd0, qp_ack, qp_retry}, 32'd1);
            chk("R1 mem addr", mem_addr, addr_of(slot));
            chk("R1 mem data", mem_data, d);
            @(posedge clk);
            #1 qp_req = 1'b0;
        end
        forever begin
            @(negedge clk);
            mem_ready = 1'($urandom_range(0, 1));
            #1;
            if (mem_valid && mem_ready) begin
                @(posedge clk);
                break;
            end
        end
        #1 mem_ready = 1'b0;
        exp_msg[slot] = d;
        hi = (hi + 1) % DEPTH;
        m_full = (hi == ti);
        m_pend = 1'b1;
        rd(2'd0, rv);
        chk("R2 head after post", rv, addr_of(hi));
        chk("R1 stored word", mem_model[slot], d);
        chk("R6 irq after post", {31'd0, irq}, {31'd0, m_pend && !m_mask});
    endtask

    task automatic consume();
        rd(2'd1, rv);
        chk("R5 tail address", rv, addr_of(ti));
        chk("R1 message at tail", mem_model[ti], exp_msg[ti]);
        wr(2'd1, addr_of(ti + 1));
        ti = (ti + 1) % DEPTH;
        m_full = 1'b0;
        rd(2'd2, rv);
        chk("R5 status after consume", rv, exp_stat());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 reset state
        rd(2'd0, rv); chk("R9 head at base", rv, BASE);
        rd(2'd1, rv); chk("R9 tail at base", rv, BASE);
        rd(2'd2, rv); chk("R9 status empty", rv, 32'd4);
        rd(2'd3, rv); chk("R9 mask clear", rv, 32'd0);
        chk("R9 irq low", {31'd0, irq}, 32'd0);

        // R1 R2 R3 directed posts with in-flight probe
        for (int i = 0; i < 3; i++) post($urandom, 1'b1);
        rd(2'd2, rv); chk("R6 status pending", rv, exp_stat());

        // R6 mask
        wr(2'd3, 32'd1); m_mask = 1'b1;
        chk("R6 irq masked", {31'd0, irq}, 32'd0);
        rd(2'd2, rv); chk("R6 pending under mask", rv, exp_stat());
        wr(2'd3, 32'd0); m_mask = 1'b0;
        #1 chk("R6 irq unmasked", {31'd0, irq}, 32'd1);

        // R7 clear while non-empty, no re-raise
        wr(2'd2, 32'd1); m_pend = 1'b0;
        rd(2'd2, rv); chk("R7 cleared", rv, exp_stat());
        repeat (5) @(posedge clk);
        #1 chk("R7 no re-raise while non-empty", {31'd0, irq}, 32'd0);

        consume();
        consume();

        // R4 fill with wrap, then retry while full
        while (!m_full) post($urandom, 1'b0);
        rd(2'd2, rv); chk("R4 status full", rv, exp_stat());
        for (int i = 0; i < 3; i++) post($urandom, 1'b0);
        rd(2'd0, rv); chk("R2 head wrapped", rv, addr_of(hi));
        consume();
        post(32'hCAFE_0001, 1'b1);

        // R7 post completing in the clear cycle
        consume();
        @(negedge clk);
        qp_req = 1'b1; qp_wdata = 32'hA5A5_0F0F; mem_ready = 1'b0;
        #1 chk("R3 ack before coincide", {30'd0, qp_ack, qp_retry}, 32'd2);
        @(posedge clk);
        #1 qp_req = 1'b0;
        @(negedge clk);
        mem_ready = 1'b1; reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'd1;
        @(posedge clk);
        #1 begin mem_ready = 1'b0; reg_we = 1'b0; end
        exp_msg[hi] = 32'hA5A5_0F0F;
        hi = (hi + 1) % DEPTH; m_full = (hi == ti); m_pend = 1'b1;
        rd(2'd2, rv); chk("R7 post wins over clear", rv, exp_stat());

        // R8 software head write on empty queue
        wr(2'd2, 32'd1); m_pend = 1'b0;
        while (count() > 0) consume();
        wr(2'd0, addr_of(ti)); m_full = 1'b1;
        rd(2'd2, rv); chk("R8 sw head makes full", rv, exp_stat());
        @(negedge clk);
        qp_req = 1'b1;
        #1 chk("R8 retry after sw head", {30'd0, qp_ack, qp_retry}, 32'd1);
        @(posedge clk);
        #1 qp_req = 1'b0;
        wr(2'd1, addr_of(ti)); m_full = 1'b0;
        rd(2'd2, rv); chk("R8 sw tail makes empty", rv, exp_stat());

        // Random mix
        for (int i = 0; i < 60; i++) begin
            if (($urandom_range(0, 1) == 1 && count() < DEPTH) || count() == 0)
                post($urandom, 1'($urandom_range(0, 1)));
            else
                consume();
            if ($urandom_range(0, 7) == 0) begin
                wr(2'd2, 32'd1); m_pend = 1'b0;
            end
        end
        rd(2'd2, rv); chk("R6 final status", rv, exp_stat());

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule